// File: doc/BRIEF.md
# Universal Bidirectional Shift Register

This block is a small word register whose next contents are picked, on every rising clock edge, by a two-bit mode code. It can keep its word, move every bit one place toward the low end, move every bit one place toward the high end, or take a whole new word from its parallel input. During a move, one serial input supplies the bit that enters the vacated end. A synchronous clear drives the whole word to zero and wins over any mode.

The word is `WIDTH` bits wide, with a default of 4. Bit `WIDTH-1` is the left end and bit 0 is the right end. The full word is always visible on the parallel output. The bits at the two ends are also brought out as serial outputs, so that a neighbouring stage can take them when the word moves. Each bit position has its own four-way selector. The selector chooses among the bit's current value, its left neighbour, its right neighbour, and its parallel input bit. A small decoder turns the mode code and the clear into the strobes that steer the selectors.

Top module: `ushift_reg`

## Requirements
- R1: With `clr` low and `mode` = 2'b00, the word on `parOut` after the rising edge equals the word before it.
- R2: With `clr` low and `mode` = 2'b01 (move right), bit i takes the old bit i+1 for i < WIDTH-1, and bit WIDTH-1 takes `serInLeft`.
- R3: With `clr` low and `mode` = 2'b10 (move left), bit i takes the old bit i-1 for i > 0, and bit 0 takes `serInRight`.
- R4: With `clr` low and `mode` = 2'b11, `parOut` takes `parIn` in full, on one edge.
- R5: With `clr` high, `parOut` is all zeros after the next rising edge, whatever the values of `mode`, `parIn` and the serial inputs.
- R6: `serOutLeft` always equals `parOut[WIDTH-1]`, and `serOutRight` always equals `parOut[0]`. Both come straight from the stored bits.
- R7: The stored word changes only on a rising clock edge. Input changes between edges have no effect on `parOut` until the next edge, and only the input values present at that edge matter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All bits update on its rising edge. |
| clr | input | 1 | Synchronous clear, active high. Overrides the mode. |
| mode | input | 2 | 00 hold, 01 move right, 10 move left, 11 parallel load. |
| serInLeft | input | 1 | Bit that enters at position WIDTH-1 on a move right. |
| serInRight | input | 1 | Bit that enters at position 0 on a move left. |
| parIn | input | WIDTH | Word taken in parallel-load mode. |
| parOut | output | WIDTH | The stored word. |
| serOutLeft | output | 1 | Stored bit WIDTH-1. |
| serOutRight | output | 1 | Stored bit 0. |

## Verification
Every result of this block is due exactly one rising edge after the inputs that cause it:
- a hold, a move in either direction, a load and a clear all appear after that one edge;
- the two serial outputs follow the stored word with no delay at all.

The bench therefore sets the inputs at a falling edge and compares against its own model at the following falling edge. That compare point is half a period clear of the edge that does the update.

One directed test also samples the word between a mid-cycle change of the inputs and the next rising edge. This shows that the word does not move before that edge.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

  // Mode code at the block edge. The encoding is part of the interface.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } modeCode_t;

  // Source that each bit's selector picks.
  typedef enum logic [1:0] {
    SEL_OWN   = 2'b00,
    SEL_LEFT  = 2'b01,
    SEL_RIGHT = 2'b10,
    SEL_PAR   = 2'b11
  } cellSel_t;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic     zero;
    cellSel_t sel;
  } ctlStrobes_t;

endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
  import ushift_pkg::*;
(
  input  logic        clr,
  input  logic [1:0]  mode,
  output ctlStrobes_t strobes
);

  modeCode_t modeCode;

  assign modeCode = modeCode_t'(mode);

  always_comb begin
    strobes.zero = clr;
    unique case (modeCode)
      MODE_HOLD:  strobes.sel = SEL_OWN;
      MODE_RIGHT: strobes.sel = SEL_LEFT;
      MODE_LEFT:  strobes.sel = SEL_RIGHT;
      MODE_LOAD:  strobes.sel = SEL_PAR;
      default:    strobes.sel = SEL_OWN;
    endcase
  end

endmodule

// File: rtl/ushift_cell.sv
module ushift_cell
  import ushift_pkg::*;
(
  input  logic        clk,
  input  ctlStrobes_t strobes,
  input  logic        leftNb,
  input  logic        rightNb,
  input  logic        parBit,
  output logic        q
);

  logic nextQ;

  always_comb begin
    unique case (strobes.sel)
      SEL_OWN:   nextQ = q;
      SEL_LEFT:  nextQ = leftNb;
      SEL_RIGHT: nextQ = rightNb;
      SEL_PAR:   nextQ = parBit;
      default:   nextQ = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.zero) q <= 1'b0;
    else              q <= nextQ;
  end

endmodule

// File: rtl/ushift_datapath.sv
module ushift_datapath
  import ushift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  ctlStrobes_t      strobes,
  input  logic             serInLeft,
  input  logic             serInRight,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] word
);

  localparam int LeftIdx  = WIDTH - 1;
  localparam int RightIdx = 0;

  for (genvar i = 0; i < WIDTH; i++) begin : gCell
    logic leftNb;
    logic rightNb;

    if (i == LeftIdx) begin : gLeftEnd
      assign leftNb = serInLeft;
    end else begin : gLeftInner
      assign leftNb = word[i+1];
    end

    if (i == RightIdx) begin : gRightEnd
      assign rightNb = serInRight;
    end else begin : gRightInner
      assign rightNb = word[i-1];
    end

    ushift_cell uCell (
      .clk     (clk),
      .strobes (strobes),
      .leftNb  (leftNb),
      .rightNb (rightNb),
      .parBit  (parIn[i]),
      .q       (word[i])
    );
  end

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [1:0]       mode,
  input  logic             serInLeft,
  input  logic             serInRight,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] parOut,
  output logic             serOutLeft,
  output logic             serOutRight
);

  ctlStrobes_t      strobes;
  logic [WIDTH-1:0] word;

  ushift_ctrl uCtrl (
    .clr     (clr),
    .mode    (mode),
    .strobes (strobes)
  );

  ushift_datapath #(.WIDTH(WIDTH)) uData (
    .clk        (clk),
    .strobes    (strobes),
    .serInLeft  (serInLeft),
    .serInRight (serInRight),
    .parIn      (parIn),
    .word       (word)
  );

  assign parOut      = word;
  assign serOutLeft  = word[WIDTH-1];
  assign serOutRight = word[0];

endmodule

// File: rtl/ushift_reg_chk.sv
module ushift_reg_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             clr,
  input logic [1:0]       mode,
  input logic             serInLeft,
  input logic             serInRight,
  input logic [WIDTH-1:0] parIn,
  input logic [WIDTH-1:0] parOut,
  input logic             serOutLeft,
  input logic             serOutRight
);

  // The checks start once a clear has put the word into a known state.
  logic started = 1'b0;

  always_ff @(posedge clk) started <= started | clr;

  assert_hold_R1: assert property (@(posedge clk) disable iff (!started)
    (!clr && mode == 2'b00) |=> parOut == $past(parOut));

  assert_move_right_R2: assert property (@(posedge clk) disable iff (!started)
    (!clr && mode == 2'b01) |=> parOut == {$past(serInLeft), $past(parOut[WIDTH-1:1])});

  assert_move_left_R3: assert property (@(posedge clk) disable iff (!started)
    (!clr && mode == 2'b10) |=> parOut == {$past(parOut[WIDTH-2:0]), $past(serInRight)});

  assert_load_R4: assert property (@(posedge clk) disable iff (!started)
    (!clr && mode == 2'b11) |=> parOut == $past(parIn));

  assert_clear_R5: assert property (@(posedge clk) disable iff (!started)
    clr |=> parOut == '0);

  assert_serial_out_R6: assert property (@(posedge clk) disable iff (!started)
    (serOutLeft == parOut[WIDTH-1]) && (serOutRight == parOut[0]));

endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH)) uChk (
  .clk         (clk),
  .clr         (clr),
  .mode        (mode),
  .serInLeft   (serInLeft),
  .serInRight  (serInRight),
  .parIn       (parIn),
  .parOut      (parOut),
  .serOutLeft  (serOutLeft),
  .serOutRight (serOutRight)
);

// File: tb/tb_ushift_reg.sv
module tb_ushift_reg;

  localparam int W     = 4;
  localparam int NVEC  = 12;
  localparam int NRAND = 150;

  logic         clk = 1'b0;
  logic         clr;
  logic [1:0]   mode;
  logic         serInLeft;
  logic         serInRight;
  logic [W-1:0] parIn;
  logic [W-1:0] parOut;
  logic         serOutLeft;
  logic         serOutRight;

  int checks = 0;
  int fails  = 0;
  logic [W-1:0] model;

  always #2 clk = ~clk;

  ushift_reg #(.WIDTH(W)) dut (
    .clk         (clk),
    .clr         (clr),
    .mode        (mode),
    .serInLeft   (serInLeft),
    .serInRight  (serInRight),
    .parIn       (parIn),
    .parOut      (parOut),
    .serOutLeft  (serOutLeft),
    .serOutRight (serOutRight)
  );

  // Each vector packs {clr, mode[1:0], serInLeft, serInRight, parIn[3:0]}.
  localparam logic [8:0] VEC [NVEC] = '{
    9'b0_11_0_0_1010, 9'b0_01_1_0_0000, 9'b0_01_0_0_0000, 9'b0_00_1_1_1111,
    9'b0_10_0_1_0000, 9'b0_10_0_0_0000, 9'b1_11_1_1_1111, 9'b0_11_0_0_0110,
    9'b0_10_1_1_0000, 9'b0_01_0_1_0000, 9'b1_01_1_0_0000, 9'b0_00_0_0_1001
  };

  // Reference model, written from the requirements.
  function automatic logic [W-1:0] refNext(logic [W-1:0] cur, logic c, logic [1:0] m,
                                           logic sl, logic sr, logic [W-1:0] p);
    if (c) return '0;
    case (m)
      2'b00:   return cur;
      2'b01:   return {sl, cur[W-1:1]};
      2'b10:   return {cur[W-2:0], sr};
      default: return p;
    endcase
  endfunction

  function automatic string reqOf(logic c, logic [1:0] m);
    if (c) return "R5";
    case (m)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (parOut !== exp) begin
      fails++;
      $display("FAIL %s parOut actual=%b expected=%b", req, parOut, exp);
    end
    checks++;
    if (serOutLeft !== exp[W-1] || serOutRight !== exp[0]) begin
      fails++;
      $display("FAIL R6 serial outs actual=%b%b expected=%b%b",
               serOutLeft, serOutRight, exp[W-1], exp[0]);
    end
  endtask

  // Drive at a falling edge; the rising edge updates; check at the next falling edge.
  task automatic step(logic c, logic [1:0] m, logic sl, logic sr, logic [W-1:0] p, string req);
    clr = c; mode = m; serInLeft = sl; serInRight = sr; parIn = p;
    model = refNext(model, c, m, sl, sr, p);
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    clr = 1'b1; mode = 2'b11; serInLeft = 1'b1; serInRight = 1'b1; parIn = '1;
    model = '0;
    @(negedge clk);
    @(negedge clk);
    check("R5 reset state", '0);

    // Vector table.
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][8], VEC[i][7:6], VEC[i][5], VEC[i][4], VEC[i][3:0],
           reqOf(VEC[i][8], VEC[i][7:6]));
    end

    // Fill with ones from the left end, then empty through the right-end input.
    for (int i = 0; i < W; i++) step(1'b0, 2'b01, 1'b1, 1'b0, '0, "R2 fill");
    check("R2 all ones", '1);
    for (int i = 0; i < W; i++) step(1'b0, 2'b10, 1'b0, 1'b0, '1, "R3 drain");
    check("R3 all zeros", '0);

    // Clear wins over a load of all ones.
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b0110, "R4");
    step(1'b1, 2'b11, 1'b1, 1'b1, '1, "R5 clear beats load");

    // An input change between edges has no effect until the next rising edge.
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1001, "R4");
    clr = 1'b0; mode = 2'b11; parIn = 4'b0101;
    #1;
    check("R7 before edge", model);
    parIn = 4'b1100;
    model = 4'b1100;
    @(negedge clk);
    check("R7 last value wins", model);

    // Random sequences over every mode.
    for (int i = 0; i < NRAND; i++) begin
      logic c;
      logic [1:0] m;
      c = ($urandom_range(0, 15) == 0);
      m = 2'($urandom_range(0, 3));
      step(c, m, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           W'($urandom_range(0, (1 << W) - 1)), reqOf(c, m));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule